// File: doc/BRIEF.md
# Program Counter and Call-Return Unit

This unit holds the program counter of an 8-bit microcontroller core and works out the next instruction address for each decoded control-flow command. It handles:

- plain sequential advance;
- 11-bit in-page jumps and calls;
- 16-bit long jumps and calls;
- signed short relative branches;
- the indirect jump through the data pointer plus the accumulator.

Branch conditions are evaluated elsewhere. A relative-branch command reaching this unit means the branch is taken.

Calls and returns use a byte-wide port into internal RAM. The unit owns the stack pointer. It moves one return-address byte per clock, and it raises `busy` for the duration so that the fetch stage holds off.

The RAM port reads combinationally: `ram_rdata` must show the byte at `ram_addr` in the same cycle. Writes take effect at the clock edge where `ram_we` is high.

Top module: `pc_flow_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0x0000, `sp` becomes 0x07 and `busy` becomes 0. The RAM strobes `ram_we`, `ram_re` and `irq_reen` stay low in the cycle after reset.
- R2: `cmd` 0 (advance), and every unassigned code 9 to 15, moves `pc` to `pc + ins_len` modulo 65536 at the accepting edge. `ins_len` is the instruction byte count.
- R3: `cmd` 1 (page jump) and `cmd` 2 (page call) treat the instruction as 2 bytes long, whatever `ins_len` says. Their target is built as follows:
  - bits 15..11 come from `pc + 2`;
  - bits 10..8 are `opcode` bits 7..5;
  - bits 7..0 are `op1`.
- R4: `cmd` 3 (long jump) and `cmd` 4 (long call) target `{op1, op2}`, with `op1` as the high byte. A long call treats the instruction as 3 bytes, so its return address is `pc + 3`.
- R5: A call pushes its return address in two cycles. The low byte is written at `sp + 1`, then the high byte at `sp + 2`. `sp` ends 2 higher, and `pc` takes the target at the edge of the second write.
- R6: `cmd` 7 (return) takes two cycles. It first reads the high byte at `sp`, then the low byte at `sp - 1`. `sp` ends 2 lower, and `pc` loads the popped address at the second edge.
- R7: `cmd` 8 (interrupt return) behaves exactly like R6. It also raises `irq_reen` for one cycle, during the low-byte read.
- R8: `cmd` 5 (taken relative branch) sets `pc` to `pc + ins_len` plus `rel_ofs` read as a signed byte (-128..+127), modulo 65536.
- R9: `cmd` 6 (indirect jump) sets `pc` to `dptr + acc` modulo 65536.
- R10: After a call or a return is accepted, `busy` is high for exactly two cycles. While `busy` is high, `cmd_valid` is ignored and `pc` does not change except for the final load.
- R11: Stack pointer arithmetic wraps modulo 256 in both directions: pushes pass from 0xFF to 0x00, and pops pass from 0x00 back to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd | input | 4 | Control-flow command code |
| ins_len | input | 2 | Byte length of the current instruction |
| opcode | input | 8 | First instruction byte; bits 7..5 give the page |
| op1 | input | 8 | Second instruction byte |
| op2 | input | 8 | Third instruction byte |
| rel_ofs | input | 8 | Signed relative branch offset |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| ram_rdata | input | 8 | Byte read from internal RAM at `ram_addr` |
| ram_we | output | 1 | Stack write strobe |
| ram_re | output | 1 | Stack read strobe |
| ram_addr | output | 8 | Stack RAM address |
| ram_wdata | output | 8 | Byte to write |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack sequence in progress; the fetch stage stalls |
| irq_reen | output | 1 | One-cycle pulse on interrupt return |

## Verification
The hardest case to reach is stack-pointer wrap-around, because `sp` only moves through pushes and pops from its reset value of 0x07. The bench issues 125 back-to-back long calls, so that the last call's two bytes straddle addresses 0xFF, 0x00 and 0x01. A return then has to pop across the same boundary.

Page targets are exercised where `pc + 2` crosses into a new 2K block, which shows that the upper five bits come from the following instruction. Relative and indirect targets are exercised on both sides of the 64K wrap.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int PC_W   = 16;
    localparam int BYTE_W = 8;
    localparam int PAGE_W = 3;

    typedef enum logic [3:0] {
        CMD_SEQ   = 4'd0,
        CMD_PJMP  = 4'd1,
        CMD_PCALL = 4'd2,
        CMD_LJMP  = 4'd3,
        CMD_LCALL = 4'd4,
        CMD_REL   = 4'd5,
        CMD_IND   = 4'd6,
        CMD_RET   = 4'd7,
        CMD_RETI  = 4'd8
    } pcu_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_HI,
        ST_POP_LO
    } stk_state_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic reti;
    } flow_kind_t;

    // Effective instruction length: fixed for page and long forms.
    function automatic logic [1:0] eff_len(input pcu_cmd_e c, input logic [1:0] given);
        case (c)
            CMD_PJMP, CMD_PCALL: eff_len = 2'd2;
            CMD_LJMP, CMD_LCALL: eff_len = 2'd3;
            default:             eff_len = given;
        endcase
    endfunction

endpackage

// File: rtl/pcu_target.sv
module pcu_target
    import pcu_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int BW = BYTE_W,
    parameter int PW = PAGE_W
) (
    input  logic [3:0]    cmd,
    input  logic [AW-1:0] pc,
    input  logic [1:0]    ins_len,
    input  logic [BW-1:0] opcode,
    input  logic [BW-1:0] op1,
    input  logic [BW-1:0] op2,
    input  logic [BW-1:0] rel_ofs,
    input  logic [BW-1:0] acc,
    input  logic [AW-1:0] dptr,
    output logic [AW-1:0] target,
    output logic [AW-1:0] ret_addr,
    output flow_kind_t    kind
);
    localparam int KEEP_LSB = BW + PW;

    pcu_cmd_e      c;
    logic [1:0]    len;
    logic [AW-1:0] next_pc;
    logic [AW-1:0] page_tgt;
    logic [AW-1:0] long_tgt;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] ind_tgt;

    always_comb begin
        c        = pcu_cmd_e'(cmd);
        len      = eff_len(c, ins_len);
        next_pc  = pc + AW'(len);
        page_tgt = {next_pc[AW-1:KEEP_LSB], opcode[BW-1 -: PW], op1};
        long_tgt = AW'({op1, op2});
        rel_tgt  = next_pc + {{(AW-BW){rel_ofs[BW-1]}}, rel_ofs};
        ind_tgt  = dptr + AW'(acc);
    end

    always_comb begin
        kind   = '0;
        target = next_pc;
        case (c)
            CMD_PJMP:  target = page_tgt;
            CMD_PCALL: begin target = page_tgt; kind.call = 1'b1; end
            CMD_LJMP:  target = long_tgt;
            CMD_LCALL: begin target = long_tgt; kind.call = 1'b1; end
            CMD_REL:   target = rel_tgt;
            CMD_IND:   target = ind_tgt;
            CMD_RET:   kind.ret = 1'b1;
            CMD_RETI:  begin kind.ret = 1'b1; kind.reti = 1'b1; end
            default:   target = next_pc;
        endcase
    end

    assign ret_addr = next_pc;

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack
    import pcu_pkg::*;
#(
    parameter int          AW     = PC_W,
    parameter int          BW     = BYTE_W,
    parameter logic [7:0]  SP_RST = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  flow_kind_t    kind,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] ret_addr,
    input  logic [BW-1:0] ram_rdata,
    output logic          busy,
    output logic          ram_we,
    output logic          ram_re,
    output logic [BW-1:0] ram_addr,
    output logic [BW-1:0] ram_wdata,
    output logic [BW-1:0] sp,
    output logic          load_en,
    output logic [AW-1:0] load_pc,
    output logic          irq_reen
);
    localparam int HI_LSB = AW - BW;

    stk_state_e    state;
    logic [BW-1:0] sp_q;
    logic [AW-1:0] ret_q;
    logic [AW-1:0] tgt_q;
    logic [BW-1:0] hi_q;
    logic          reti_q;
    logic [BW-1:0] sp_up;
    logic [BW-1:0] sp_dn;

    assign sp_up = sp_q + BW'(1);
    assign sp_dn = sp_q - BW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sp_q   <= BW'(SP_RST);
            ret_q  <= '0;
            tgt_q  <= '0;
            hi_q   <= '0;
            reti_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && kind.call) begin
                        ret_q <= ret_addr;
                        tgt_q <= target;
                        state <= ST_PUSH_LO;
                    end else if (start && kind.ret) begin
                        reti_q <= kind.reti;
                        state  <= ST_POP_HI;
                    end
                end
                ST_PUSH_LO: begin
                    sp_q  <= sp_up;
                    state <= ST_PUSH_HI;
                end
                ST_PUSH_HI: begin
                    sp_q  <= sp_up;
                    state <= ST_IDLE;
                end
                ST_POP_HI: begin
                    hi_q  <= ram_rdata;
                    sp_q  <= sp_dn;
                    state <= ST_POP_LO;
                end
                ST_POP_LO: begin
                    sp_q  <= sp_dn;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_we    = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
        ram_re    = (state == ST_POP_HI) || (state == ST_POP_LO);
        ram_addr  = ram_we ? sp_up : sp_q;
        ram_wdata = (state == ST_PUSH_LO) ? ret_q[BW-1:0] : ret_q[AW-1:HI_LSB];
        load_en   = (state == ST_PUSH_HI) || (state == ST_POP_LO);
        load_pc   = (state == ST_PUSH_HI) ? tgt_q : AW'({hi_q, ram_rdata});
        irq_reen  = (state == ST_POP_LO) && reti_q;
        busy      = (state != ST_IDLE);
    end

    assign sp = sp_q;

    // R5: each written byte advances the pointer first
    p_push_preinc_r5: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (sp == $past(sp) + BW'(1)));

    // R5: never write and read in the same cycle
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, ram_re}));

    // R6: each read byte lowers the pointer afterwards
    p_pop_postdec_r6: assert property (@(posedge clk) disable iff (rst)
        ram_re |=> (sp == $past(sp) - BW'(1)));

    // R7: re-enable pulse only accompanies a stack read
    p_reen_on_pop_r7: assert property (@(posedge clk) disable iff (rst)
        irq_reen |-> ram_re);

    // R10: a push sequence is always two cycles long
    p_push_pair_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH_LO) |=> (state == ST_PUSH_HI));

endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit
    import pcu_pkg::*;
#(
    parameter int         AW     = PC_W,
    parameter int         BW     = BYTE_W,
    parameter int         PW     = PAGE_W,
    parameter logic [7:0] SP_RST = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd,
    input  logic [1:0]    ins_len,
    input  logic [BW-1:0] opcode,
    input  logic [BW-1:0] op1,
    input  logic [BW-1:0] op2,
    input  logic [BW-1:0] rel_ofs,
    input  logic [BW-1:0] acc,
    input  logic [AW-1:0] dptr,
    input  logic [BW-1:0] ram_rdata,
    output logic          ram_we,
    output logic          ram_re,
    output logic [BW-1:0] ram_addr,
    output logic [BW-1:0] ram_wdata,
    output logic [AW-1:0] pc,
    output logic [BW-1:0] sp,
    output logic          busy,
    output logic          irq_reen
);
    logic [AW-1:0] target;
    logic [AW-1:0] ret_addr;
    flow_kind_t    kind;
    logic          accept;
    logic          load_en;
    logic [AW-1:0] load_pc;
    logic [AW-1:0] pc_q;

    pcu_target #(.AW(AW), .BW(BW), .PW(PW)) u_target (
        .cmd      (cmd),
        .pc       (pc_q),
        .ins_len  (ins_len),
        .opcode   (opcode),
        .op1      (op1),
        .op2      (op2),
        .rel_ofs  (rel_ofs),
        .acc      (acc),
        .dptr     (dptr),
        .target   (target),
        .ret_addr (ret_addr),
        .kind     (kind)
    );

    assign accept = cmd_valid && !busy;

    pcu_stack #(.AW(AW), .BW(BW), .SP_RST(SP_RST)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .kind      (kind),
        .target    (target),
        .ret_addr  (ret_addr),
        .ram_rdata (ram_rdata),
        .busy      (busy),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .sp        (sp),
        .load_en   (load_en),
        .load_pc   (load_pc),
        .irq_reen  (irq_reen)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (load_en)
            pc_q <= load_pc;
        else if (accept && !kind.call && !kind.ret)
            pc_q <= target;
    end

    assign pc = pc_q;

    // R4: a long jump lands on the two operand bytes
    p_long_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd == 4'd3) |=> (pc == AW'($past({op1, op2}))));

    // R10: with no accepted command and no stack load, pc holds
    p_stall_pc_r10: assert property (@(posedge clk) disable iff (rst)
        (!accept && !load_en) |=> $stable(pc));

    // R10: a call or return accepted raises busy on the next cycle
    p_busy_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (accept && (kind.call || kind.ret)) |=> busy);

endmodule

// File: tb/pc_flow_unit_bench.sv
module pc_flow_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [3:0]  cmd;
    logic [1:0]  ins_len;
    logic [7:0]  opcode, op1, op2, rel_ofs, acc;
    logic [15:0] dptr;
    logic [7:0]  ram_rdata;
    logic        ram_we, ram_re, busy, irq_reen;
    logic [7:0]  ram_addr, ram_wdata, sp;
    logic [15:0] pc;

    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    int          reen_cnt = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    pc_flow_unit u_pc_flow_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .ins_len(ins_len),
        .opcode(opcode), .op1(op1), .op2(op2), .rel_ofs(rel_ofs), .acc(acc),
        .dptr(dptr), .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .pc(pc), .sp(sp),
        .busy(busy), .irq_reen(irq_reen)
    );

    assign ram_rdata = mem[ram_addr];

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (irq_reen) reen_cnt <= reen_cnt + 1;
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (act cycles %0d, exp fewer)", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] len, input logic [7:0] opc,
                         input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] ofs,
                         output int bcyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; ins_len = len; opcode = opc;
        op1 = b1; op2 = b2; rel_ofs = ofs;
        @(negedge clk);
        cmd_valid = 1'b0;
        bcyc = 0;
        while (busy) begin
            bcyc = bcyc + 1;
            @(negedge clk);
        end
    endtask

    task automatic jump_to(input logic [15:0] a);
        int b;
        issue(4'd3, 2'd3, 8'h02, a[15:8], a[7:0], 8'h00, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", pc, 16'h0000);
        check("R1 sp", {8'h00, sp}, 16'h0007);
        check("R1 busy/strobes", {12'h000, busy, ram_we, ram_re, irq_reen}, 16'h0000);
    endtask

    task automatic t_sequential();
        int b;
        issue(4'd0, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, b);
        check("R2 advance by 1", pc, 16'h0001);
        issue(4'd0, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, b);
        check("R2 advance by 3", pc, 16'h0004);
        issue(4'd15, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, b);
        check("R2 unassigned code advances", pc, 16'h0006);
        jump_to(16'hFFFF);
        check("R4 long jump", pc, 16'hFFFF);
        issue(4'd0, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, b);
        check("R2 wrap", pc, 16'h0001);
    endtask

    task automatic t_page();
        int b;
        jump_to(16'h17FE);
        issue(4'd1, 2'd1, 8'hE1, 8'h34, 8'h00, 8'h00, b);
        check("R3 page jump across 2K block", pc, 16'h1F34);
        check("R3 page jump not busy", 16'(b), 16'd0);
    endtask

    task automatic t_calls_returns();
        int b;
        int r0;
        jump_to(16'h2100);
        issue(4'd2, 2'd3, 8'h51, 8'h99, 8'h00, 8'h00, b);
        check("R3 page call target", pc, 16'h2299);
        check("R10 call busy cycles", 16'(b), 16'd2);
        check("R5 low byte at sp+1", {8'h00, mem[8'h08]}, 16'h0002);
        check("R5 high byte at sp+2", {8'h00, mem[8'h09]}, 16'h0021);
        check("R5 sp after call", {8'h00, sp}, 16'h0009);
        issue(4'd4, 2'd1, 8'h12, 8'h45, 8'h67, 8'h00, b);
        check("R4 long call target", pc, 16'h4567);
        check("R4 long call ret low", {8'h00, mem[8'h0A]}, 16'h009C);
        check("R4 long call ret high", {8'h00, mem[8'h0B]}, 16'h0022);
        r0 = reen_cnt;
        issue(4'd7, 2'd1, 8'h22, 8'h00, 8'h00, 8'h00, b);
        check("R6 return pc", pc, 16'h229C);
        check("R6 sp after return", {8'h00, sp}, 16'h0009);
        check("R10 return busy cycles", 16'(b), 16'd2);
        check("R7 plain return no pulse", 16'(reen_cnt - r0), 16'd0);
        issue(4'd8, 2'd1, 8'h32, 8'h00, 8'h00, 8'h00, b);
        check("R7 interrupt return pc", pc, 16'h2102);
        check("R7 sp", {8'h00, sp}, 16'h0007);
        check("R7 one pulse", 16'(reen_cnt - r0), 16'd1);
    endtask

    task automatic t_relative();
        int b;
        jump_to(16'h1000);
        issue(4'd5, 2'd2, 8'h80, 8'h00, 8'h00, 8'h80, b);
        check("R8 branch -128", pc, 16'h0F82);
        issue(4'd5, 2'd3, 8'h20, 8'h00, 8'h00, 8'h7F, b);
        check("R8 branch +127 len 3", pc, 16'h1004);
        jump_to(16'hFFFE);
        issue(4'd5, 2'd2, 8'h80, 8'h00, 8'h00, 8'h05, b);
        check("R8 forward wrap", pc, 16'h0005);
        jump_to(16'h0000);
        issue(4'd5, 2'd2, 8'h80, 8'h00, 8'h00, 8'hF0, b);
        check("R8 backward wrap", pc, 16'hFFF2);
    endtask

    task automatic t_indirect();
        int b;
        dptr = 16'h1234; acc = 8'h05;
        issue(4'd6, 2'd1, 8'h73, 8'h00, 8'h00, 8'h00, b);
        check("R9 indirect", pc, 16'h1239);
        dptr = 16'hFFF0; acc = 8'h20;
        issue(4'd6, 2'd1, 8'h73, 8'h00, 8'h00, 8'h00, b);
        check("R9 indirect wrap", pc, 16'h0010);
    endtask

    task automatic t_ignored_while_busy();
        int b;
        jump_to(16'h0100);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = 4'd4; ins_len = 2'd3; op1 = 8'h50; op2 = 8'h00;
        @(negedge clk);
        // busy now; present a long jump that must be dropped
        cmd = 4'd3; op1 = 8'hAA; op2 = 8'hBB;
        check("R10 busy after accept", {15'h0, busy}, 16'h0001);
        @(negedge clk);
        check("R10 pc held while busy", pc, 16'h0100);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 busy done", {15'h0, busy}, 16'h0000);
        check("R10 command during busy ignored", pc, 16'h5000);
        issue(4'd7, 2'd1, 8'h22, 8'h00, 8'h00, 8'h00, b);
        check("R6 return after ignored", pc, 16'h0103);
    endtask

    task automatic t_sp_wrap();
        int b;
        do_reset();
        jump_to(16'h3000);
        for (int i = 0; i < 125; i++)
            issue(4'd4, 2'd3, 8'h12, 8'h30, 8'h00, 8'h00, b);
        check("R11 sp wrapped up", {8'h00, sp}, 16'h0001);
        check("R11 low byte at 0x00", {8'h00, mem[8'h00]}, 16'h0003);
        check("R11 high byte at 0x01", {8'h00, mem[8'h01]}, 16'h0030);
        check("R11 byte at 0xFF", {8'h00, mem[8'hFF]}, 16'h0030);
        issue(4'd7, 2'd1, 8'h22, 8'h00, 8'h00, 8'h00, b);
        check("R11 return across wrap pc", pc, 16'h3003);
        check("R11 sp wrapped down", {8'h00, sp}, 16'h00FF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst = 1'b1; cmd_valid = 1'b0; cmd = 4'd0; ins_len = 2'd1;
        opcode = 8'h00; op1 = 8'h00; op2 = 8'h00; rel_ofs = 8'h00;
        acc = 8'h00; dptr = 16'h0000;
        t_reset();
        t_sequential();
        t_page();
        t_calls_returns();
        t_relative();
        t_indirect();
        t_ignored_while_busy();
        t_sp_wrap();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule